// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port

This block is a bidirectional six-pin I/O port that software controls through a small register interface. It holds an output data latch, a per-pin direction register and a per-pin pull-up enable register. For every pin it drives three signals to an external pad model: an output value, an output enable and a pull-up enable. Pin levels come back on `pin_in` and pass through a two-flop synchronizer before software can read them.

Each pin can also be handed to an alternate on-chip function. While a pin is handed over, it takes its output value and output enable from that function, and the latch and direction bit of the pin have no effect on it. Pin 3 is open-drain. It can only pull low. It releases the line whenever its source value is 1, whether the pin is in general I/O use or handed to the alternate function.

Register map, selected by `addr`. Writes take effect at the clock edge where `wr_en` is sampled high. Reads are combinational.

| addr | Write | Read |
|------|-------|------|
| 0 | data latch | synchronized pin levels |
| 1 | data latch | data latch |
| 2 | direction register | direction register |
| 3 | pull-up enable register | pull-up enable register |

Top module: `pin_port6`

## Requirements
- R1: Reset (`rst_n` low) sets every direction bit to 1 (input), clears the latch and clears every pull-up enable bit. After reset, addr 2 reads 6'h3F, addr 1 and addr 3 read 0, and `pin_oe` and `pin_pu` are all 0.
- R2: A write with `wr_en` high to addr 0 or to addr 1 loads `wdata` into the latch at that clock edge. Reading addr 1 returns the latch, whatever levels are on `pin_in`.
- R3: Reading addr 0 returns `pin_in` as sampled two rising clock edges earlier. A change on `pin_in` is not visible after only one edge.
- R4: A general-purpose pin other than pin 3 with direction bit 0 has `pin_oe` 1 and `pin_out` equal to its latch bit. With direction bit 1, its `pin_oe` is 0.
- R5: Pin 3 is open-drain. Its `pin_out` is always 0. Its `pin_oe` is 1 only when the pin is configured as an output and its source value (the latch bit, or `alt_out[3]` when overridden) is 0.
- R6: `pin_pu` of a pin equals its pull-up enable bit, forced to 0 while the pin is configured as an output. For a general-purpose pin, configured as an output means direction bit 0. For an overridden pin, it means `alt_oe` is 1.
- R7: While `alt_en[i]` is 1, pin i takes its output value from `alt_out[i]` and its output configuration from `alt_oe[i]`. Its latch and direction bits have no effect on the pin.
- R8: A write to addr 2 or addr 3 loads only the direction register or the pull-up register respectively, and leaves the latch unchanged.
- R9: While `wr_en` is 0, no register changes, whatever `addr` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Read data for the selected register |
| pin_in | input | 6 | Pad input levels |
| pin_out | output | 6 | Value driven to each pad |
| pin_oe | output | 6 | Pad output enable per pin |
| pin_pu | output | 6 | Weak pull-up enable per pin |
| alt_en | input | 6 | Per-pin hand-over to the alternate function |
| alt_out | input | 6 | Alternate function output value |
| alt_oe | input | 6 | Alternate function output enable |

## Verification
Two functions can collide in the same cycle. The first is the pull-up gating, which depends on the direction register or on `alt_oe`. The second is the drive decision, which on pin 3 also depends on the latch. The bench provokes this by enabling every pull-up and then changing direction, latch and alternate-function inputs, including a hand-over of pin 3. After each change it compares `pin_oe`, `pin_out` and `pin_pu` against a model built from the requirements. A second collision involves the synchronized read path and the latch read path. The bench drives `pin_in` to values that differ from the latch and reads both addresses on the same pin pattern.

// File: rtl/pin_port6.sv
module pin_port6 #(
  parameter int WIDTH  = 6,
  parameter int OD_IDX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_pu,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] alt_oe
);
  localparam logic [1:0] A_PORT = 2'd0;
  localparam logic [1:0] A_LAT  = 2'd1;
  localparam logic [1:0] A_DIR  = 2'd2;
  localparam logic [1:0] A_PU   = 2'd3;
  localparam logic [WIDTH-1:0] OD_MASK = WIDTH'(1) << OD_IDX;

  logic [WIDTH-1:0] lat_q, dir_q, pu_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] src_val, out_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      dir_q   <= '1;
      pu_q    <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (wr_en) begin
        case (addr)
          A_PORT, A_LAT: lat_q <= wdata;
          A_DIR:         dir_q <= wdata;
          default:       pu_q  <= wdata;
        endcase
      end
    end
  end

  assign src_val = (alt_en & alt_out) | (~alt_en & lat_q);
  assign out_cfg = (alt_en & alt_oe)  | (~alt_en & ~dir_q);
  assign pin_oe  = out_cfg & ~(OD_MASK & src_val);
  assign pin_out = src_val & ~OD_MASK;
  assign pin_pu  = pu_q & ~out_cfg;

  always_comb begin
    case (addr)
      A_PORT:  rdata = sync2_q;
      A_LAT:   rdata = lat_q;
      A_DIR:   rdata = dir_q;
      A_PU:    rdata = pu_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_port6_chk.sv
module pin_port6_chk #(
  parameter int WIDTH  = 6,
  parameter int OD_IDX = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_pu,
  input logic [WIDTH-1:0] alt_en,
  input logic [WIDTH-1:0] lat_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] pu_q
);
  localparam logic [WIDTH-1:0] OD_MASK = WIDTH'(1) << OD_IDX;
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;

  // R1
  reset_val_chk: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '1 && lat_q == '0 && pu_q == '0));

  // R2
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr <= 2'd1) |=> lat_q == $past(wdata));

  // R3
  port_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && addr == 2'd0) |-> rdata == $past(pin_in, 2));

  // R4
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~alt_en & ~dir_q & ~OD_MASK) & ~(pin_oe & ~(pin_out ^ lat_q))) == '0);

  // R5
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_en[OD_IDX] && lat_q[OD_IDX]) |-> !pin_oe[OD_IDX]);

  // R6
  pu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lat_q) && $stable(dir_q) && $stable(pu_q)));
endmodule

bind pin_port6 pin_port6_chk #(.WIDTH(WIDTH), .OD_IDX(OD_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_pu(pin_pu), .alt_en(alt_en), .lat_q(lat_q), .dir_q(dir_q), .pu_q(pu_q)
);

// File: tb/sim_pin_port6.sv
`timescale 1ns/1ps
module sim_pin_port6;
  typedef struct {
    int         req;
    int         sel;
    logic [5:0] exp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [5:0] wdata = '0, pin_in = '0, alt_en = '0, alt_out = '0, alt_oe = '0;
  logic [5:0] rdata, pin_out, pin_oe, pin_pu;
  logic [5:0] m_lat = '0, m_dir = 6'h3F, m_pu = '0;
  localparam logic [5:0] OD = 6'h08;

  item_t sb[$];
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_port6 u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe));

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [5:0] act;
      it = sb.pop_front();
      case (it.sel)
        0: act = rdata;
        1: act = pin_oe;
        2: act = pin_out;
        default: act = pin_pu;
      endcase
      nvec++;
      if (act !== it.exp) begin
        nbad++;
        $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    case (a)
      2'd0, 2'd1: m_lat = d;
      2'd2: m_dir = d;
      default: m_pu = d;
    endcase
  endtask

  task automatic chk_rd(input int req, input logic [1:0] a, input logic [5:0] e);
    addr = a;
    sb.push_back('{req, 0, e});
    @(negedge clk); #1;
  endtask

  task automatic chk_pins(input int req);
    logic [5:0] cfg, src;
    cfg = (alt_en & alt_oe) | (~alt_en & ~m_dir);
    src = (alt_en & alt_out) | (~alt_en & m_lat);
    sb.push_back('{req, 1, cfg & ~(OD & src)});
    sb.push_back('{req, 2, src & ~OD});
    sb.push_back('{req, 3, m_pu & ~cfg});
    @(negedge clk); #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_rd(1, 2'd2, 6'h3F);
    chk_rd(1, 2'd1, 6'h00);
    chk_rd(1, 2'd3, 6'h00);
    chk_pins(1);
    // R2 writes through either address
    wr(2'd0, 6'h2A);
    chk_rd(2, 2'd1, 6'h2A);
    wr(2'd1, 6'h15);
    chk_rd(2, 2'd1, 6'h15);
    // R9 no write without strobe
    @(posedge clk); #1;
    addr = 2'd1; wdata = 6'h3F;
    @(posedge clk); #1;
    addr = 2'd2;
    @(posedge clk); #1;
    chk_rd(9, 2'd1, 6'h15);
    chk_rd(9, 2'd2, 6'h3F);
    // R8 direction write leaves latch
    wr(2'd2, 6'h00);
    chk_rd(8, 2'd1, 6'h15);
    chk_rd(8, 2'd2, 6'h00);
    // R4 R5 all outputs, pin 3 latch low then high
    chk_pins(4);
    wr(2'd1, 6'h3F);
    chk_pins(5);
    wr(2'd1, 6'h00);
    chk_pins(5);
    // R6 pull-ups gated by direction, R8 pull-up write leaves latch
    wr(2'd1, 6'h3F);
    wr(2'd3, 6'h3F);
    chk_rd(8, 2'd1, 6'h3F);
    chk_pins(6);
    wr(2'd2, 6'h0F);
    chk_pins(6);
    // R3 synchronizer depth, R2 latch read independent of pins
    @(posedge clk); #1 pin_in = 6'h2D;
    @(posedge clk); #1;
    chk_rd(3, 2'd0, 6'h00);
    @(posedge clk); #1;
    chk_rd(3, 2'd0, 6'h2D);
    chk_rd(2, 2'd1, 6'h3F);
    @(posedge clk); #1 pin_in = 6'h12;
    repeat (2) @(posedge clk); #1;
    chk_rd(3, 2'd0, 6'h12);
    // R7 alternate function override
    alt_en = 6'h21; alt_out = 6'h01; alt_oe = 6'h21;
    chk_pins(7);
    alt_oe = 6'h20;
    chk_pins(7);
    // R5 R7 override of the open-drain pin
    alt_en = 6'h08; alt_out = 6'h08; alt_oe = 6'h08;
    chk_pins(5);
    alt_out = 6'h00;
    chk_pins(5);
    wr(2'd2, 6'h3F);
    chk_pins(7);
    alt_en = '0;
    chk_pins(6);
    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule